// File: doc/BRIEF.md
# Mode-Switchable Carry-Save Arithmetic Array

This block is an N-by-N grid of identical arithmetic cells that computes one of three operations: an unsigned two-operand product, a chained sum, or a chained difference. The wiring between cells never changes. Each cell takes a vertical link from the cell directly above it and a diagonal link from the cell above and to the left. The operating mode only changes what a cell computes and which of its two full-adder outputs it drives onto each link.

In multiply mode the multiplicand enters the grid bit-reversed, so column j carries multiplicand bit N-1-j. Row i receives bit i of the first row word, which acts as the multiplier. In the add and subtract modes every row brings its own N-bit word. Subtraction inverts each row bit inside the cell. The last row's sum and carry vectors, together with the bits that leave the right edge of the grid, go to a final resolving adder. That adder also adds the multiplicand word, which serves as the base operand in the chained modes, and a fixed correction that completes the two's complement of each subtracted row.

The result is captured in an output register together with a valid strobe. The register updates only when an input is presented.

Top module: `mcsa_top`

## Requirements
- R1: With mode = 2'b00, the result is the unsigned product of `mcand` and the first row word `rows[N-1:0]`, 2N bits wide.
- R2: In mode 2'b00, the row words 1 to N-1 (`rows[N*N-1:N]`) have no effect on the result.
- R3: With mode = 2'b01, the result is `mcand` plus the sum of all N row words, where row k is `rows[k*N +: N]`, 2N bits wide.
- R4: With mode = 2'b10, the result is `mcand` minus the sum of all N row words, given as a 2N-bit two's complement value.
- R5: With mode = 2'b11 (reserved), the result is zero.
- R6: `out_valid` is high in the cycle after `in_valid` was sampled high and low in the cycle after it was sampled low. The result for an input appears in that same cycle.
- R7: While `rst_n` is low, `result` and `out_valid` are zero.
- R8: Operands at their extremes resolve without loss: an all-ones multiply gives (2^N-1)^2, an all-ones add gives (N+1)(2^N-1), and a zero base minus all-ones rows gives -N(2^N-1).
- R9: When `in_valid` is sampled low, `result` keeps its previous value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and mode are presented this cycle |
| mode | input | 2 | 00 multiply, 01 chained add, 10 chained subtract, 11 reserved |
| mcand | input | N | Multiplicand, or base operand in the chained modes |
| rows | input | N*N | One N-bit word per row; row k at bits k*N+N-1 down to k*N |
| result | output | 2N | Registered result |
| out_valid | output | 1 | Result is fresh this cycle |

## Verification
Every result and its valid strobe are due exactly one clock edge after the edge that samples `in_valid`, because the grid and the resolving adder are combinational and feed a single output register. The bench keeps a behavioural model that advances on the same edge and holds the expected value and the expected strobe. It compares both against the outputs at the following falling edge, every cycle. Cycles without a valid input are compared against the held value, which covers the hold rule.

// File: rtl/mcsa_pkg.sv
package mcsa_pkg;

    typedef enum logic [1:0] {
        MODE_MUL = 2'b00,
        MODE_ADD = 2'b01,
        MODE_SUB = 2'b10,
        MODE_RSV = 2'b11
    } mcsa_mode_e;

endpackage

// File: rtl/mcsa_cell.sv
module mcsa_cell
    import mcsa_pkg::*;
(
    input  mcsa_mode_e mode,
    input  logic       mcand_bit,
    input  logic       mplier_bit,
    input  logic       op_bit,
    input  logic       vert_in,
    input  logic       diag_in,
    output logic       vert_out,
    output logic       diag_out
);

    logic term;
    logic fa_s;
    logic fa_c;

    // Third addend depends on the mode; the other two come over fixed links.
    always_comb begin
        unique case (mode)
            MODE_MUL: term = mcand_bit & mplier_bit;
            MODE_ADD: term = op_bit;
            MODE_SUB: term = ~op_bit;
            default:  term = 1'b0;
        endcase
    end

    assign fa_s = term ^ vert_in ^ diag_in;
    assign fa_c = (term & vert_in) | (term & diag_in) | (vert_in & diag_in);

    // Port permutation: in multiply mode the carry travels straight down and
    // the sum travels diagonally; in the chained modes it is the other way.
    assign vert_out = (mode == MODE_MUL) ? fa_c : fa_s;
    assign diag_out = (mode == MODE_MUL) ? fa_s : fa_c;

endmodule

// File: rtl/mcsa_grid.sv
module mcsa_grid
    import mcsa_pkg::*;
#(
    parameter int N = 8
) (
    input  mcsa_mode_e       mode,
    input  logic [N-1:0]     mcand,
    input  logic [N*N-1:0]   rows,
    output logic [N-1:0]     last_vert,
    output logic [N-1:0]     last_diag,
    output logic [N-2:0]     edge_diag
);

    logic vert_w [N][N];
    logic diag_w [N][N];

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            logic v_in;
            logic d_in;

            if (i == 0) begin : g_top
                assign v_in = 1'b0;
                assign d_in = 1'b0;
            end else begin : g_inner
                assign v_in = vert_w[i-1][j];
                if (j == 0) begin : g_left
                    assign d_in = 1'b0;
                end else begin : g_body
                    assign d_in = diag_w[i-1][j-1];
                end
            end

            // Multiplicand mirrored: column j sees bit N-1-j.
            mcsa_cell u_cell (
                .mode       (mode),
                .mcand_bit  (mcand[N-1-j]),
                .mplier_bit (rows[i]),
                .op_bit     (rows[i*N+j]),
                .vert_in    (v_in),
                .diag_in    (d_in),
                .vert_out   (vert_w[i][j]),
                .diag_out   (diag_w[i][j])
            );
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_last
        assign last_vert[j] = vert_w[N-1][j];
        assign last_diag[j] = diag_w[N-1][j];
    end

    for (genvar i = 0; i < N-1; i++) begin : g_edge
        assign edge_diag[i] = diag_w[i][N-1];
    end

endmodule

// File: rtl/mcsa_resolve.sv
module mcsa_resolve
    import mcsa_pkg::*;
#(
    parameter int N = 8
) (
    input  mcsa_mode_e       mode,
    input  logic [N-1:0]     mcand,
    input  logic [N-1:0]     last_vert,
    input  logic [N-1:0]     last_diag,
    input  logic [N-2:0]     edge_diag,
    output logic [2*N-1:0]   result
);

    localparam int RW = 2*N;
    localparam logic [RW-1:0] ROWS_W  = RW'(N);
    localparam logic [RW-1:0] SUB_FIX = ROWS_W - (ROWS_W << N);

    logic [RW-1:0] sum_v;
    logic [RW-1:0] car_v;
    logic [RW-1:0] extra;
    logic [RW-1:0] edge_cnt;

    always_comb begin
        sum_v    = '0;
        car_v    = '0;
        extra    = '0;
        edge_cnt = '0;
        for (int k = 0; k < N-1; k++) begin
            edge_cnt = edge_cnt + RW'(edge_diag[k]);
        end
        unique case (mode)
            MODE_MUL: begin
                // Mirrored column j of the last row sits at weight 2N-2-j.
                for (int j = 0; j < N; j++) begin
                    sum_v[2*N-2-j] = last_diag[j];
                    car_v[2*N-1-j] = last_vert[j];
                end
                // Low product bits leave the right edge one per row.
                for (int k = 0; k < N-1; k++) begin
                    sum_v[k] = edge_diag[k];
                end
            end
            MODE_ADD, MODE_SUB: begin
                for (int j = 0; j < N; j++) begin
                    sum_v[j]   = last_vert[j];
                    car_v[j+1] = last_diag[j];
                end
                // Carries that left the right edge all weigh 2^N.
                extra = (edge_cnt << N) + RW'(mcand)
                      + ((mode == MODE_SUB) ? SUB_FIX : '0);
            end
            default: begin
            end
        endcase
        result = (mode == MODE_RSV) ? '0 : (sum_v + car_v + extra);
    end

endmodule

// File: rtl/mcsa_top.sv
module mcsa_top
    import mcsa_pkg::*;
#(
    parameter int N       = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       mode,
    input  logic [N-1:0]     mcand,
    input  logic [N*N-1:0]   rows,
    output logic [2*N-1:0]   result,
    output logic             out_valid
);

    localparam int RW = 2*N;

    mcsa_mode_e    mode_e;
    logic [N-1:0]  last_vert;
    logic [N-1:0]  last_diag;
    logic [N-2:0]  edge_diag;
    logic [RW-1:0] comb_result;

    assign mode_e = mcsa_mode_e'(mode);

    mcsa_grid #(.N(N)) u_grid (
        .mode      (mode_e),
        .mcand     (mcand),
        .rows      (rows),
        .last_vert (last_vert),
        .last_diag (last_diag),
        .edge_diag (edge_diag)
    );

    mcsa_resolve #(.N(N)) u_resolve (
        .mode      (mode_e),
        .mcand     (mcand),
        .last_vert (last_vert),
        .last_diag (last_diag),
        .edge_diag (edge_diag),
        .result    (comb_result)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                result    <= '0;
                out_valid <= 1'b0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    result <= comb_result;
                end
            end
        end

        a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(result));
        a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mode == 2'b11) |=> (result == '0));
        a_r1_zero_factor: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mode == 2'b00 && (mcand == '0 || rows[N-1:0] == '0))
            |=> (result == '0));
        a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && mode == 2'b01) |=> (result >= {{N{1'b0}}, $past(mcand)}));
    end else begin : g_pass
        assign result    = comb_result;
        assign out_valid = in_valid;
    end

endmodule

// File: tb/test_mcsa_top.sv
module test_mcsa_top;

    localparam int N  = 8;
    localparam int RW = 2*N;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [1:0]      mode = 2'b00;
    logic [N-1:0]    mcand = '0;
    logic [N*N-1:0]  rows = '0;
    logic [RW-1:0]   result;
    logic            out_valid;

    int    compared = 0;
    int    mismatched = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    logic [RW-1:0] exp_r;
    logic          exp_v;
    string         exp_tag;

    always #4 clk = ~clk;

    mcsa_top #(.N(N)) i_mcsa_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .mode      (mode),
        .mcand     (mcand),
        .rows      (rows),
        .result    (result),
        .out_valid (out_valid)
    );

    function automatic logic [RW-1:0] model(input logic [1:0] m, input logic [N-1:0] a,
                                            input logic [N*N-1:0] r);
        longint acc;
        longint tot;
        tot = 0;
        for (int k = 0; k < N; k++) tot += longint'(r[k*N +: N]);
        case (m)
            2'b00:   acc = longint'(a) * longint'(r[N-1:0]);
            2'b01:   acc = longint'(a) + tot;
            2'b10:   acc = longint'(a) - tot;
            default: acc = 0;
        endcase
        return acc[RW-1:0];
    endfunction

    // Behavioural reference, advanced on the same edge as the design.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_v   <= 1'b0;
            exp_r   <= '0;
            exp_tag <= "R7";
        end else begin
            exp_v <= in_valid;
            if (in_valid) begin
                exp_r   <= model(mode, mcand, rows);
                exp_tag <= cur_tag;
            end else begin
                exp_tag <= "R9";
            end
        end
    end

    task automatic check(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check(rst_n ? "R6" : "R7", RW'(out_valid), RW'(exp_v));
            check(exp_tag, result, exp_r);
        end
    end

    task automatic drive(input logic v, input logic [1:0] m, input logic [N-1:0] a,
                         input logic [N*N-1:0] r);
        @(negedge clk);
        in_valid = v;
        mode     = m;
        mcand    = a;
        rows     = r;
    endtask

    function automatic logic [N*N-1:0] rnd_rows();
        return {$urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_tag = "R1";   // R1: multiplier in row 0 only
        for (int n = 0; n < 200; n++)
            drive(1'b1, 2'b00, N'($urandom), {{(N*N-N){1'b0}}, N'($urandom)});

        cur_tag = "R2";   // R2: upper rows random, must not matter
        for (int n = 0; n < 100; n++)
            drive(1'b1, 2'b00, N'($urandom), rnd_rows());

        cur_tag = "R3";
        for (int n = 0; n < 200; n++)
            drive(1'b1, 2'b01, N'($urandom), rnd_rows());

        cur_tag = "R4";
        for (int n = 0; n < 200; n++)
            drive(1'b1, 2'b10, N'($urandom), rnd_rows());

        cur_tag = "R5";
        for (int n = 0; n < 50; n++)
            drive(1'b1, 2'b11, N'($urandom), rnd_rows());

        cur_tag = "R8";   // R8: extremes
        drive(1'b1, 2'b00, '1, '1);
        drive(1'b1, 2'b01, '1, '1);
        drive(1'b1, 2'b10, '0, '1);
        drive(1'b1, 2'b10, '1, '0);
        drive(1'b1, 2'b00, '0, '1);
        drive(1'b1, 2'b01, '0, '0);

        cur_tag = "R9";   // R9: idle cycles with changing inputs
        drive(1'b1, 2'b01, N'($urandom), rnd_rows());
        for (int n = 0; n < 20; n++)
            drive(1'b0, 2'($urandom), N'($urandom), rnd_rows());

        cur_tag = "R6";   // R6: sparse valid strobes across all modes
        for (int n = 0; n < 300; n++)
            drive(1'($urandom), 2'($urandom), N'($urandom), rnd_rows());

        drive(1'b0, 2'b00, '0, '0);
        drive(1'b0, 2'b00, '0, '0);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule